// File: doc/BRIEF.md
# Queued command issue scheduler

The scheduler keeps track of command slots that host software has posted for native queued execution and hands them to a link-layer model one at a time. A host-side write names a slot. The write sets that slot's bit in a 32-bit issue bitmap and in a matching active bitmap. The scheduler picks the lowest-numbered pending slot and requests a transmit. The tag it sends is the slot number. It then waits for the device's register FIS before it will transmit anything else.

The number of usable slots is the smaller of the host slot count (a parameter) and the queue depth the device reports. A posting aimed at a slot outside that window is dropped and raises a sticky range error. While the scheduler is idle, an inbound FIS that is pending always goes ahead of issuing the next command. A register FIS with its interrupt bit clear retires the issue bit quietly. If the interrupt bit is set, the same FIS also produces a one-cycle interrupt pulse. Command completion for the active bitmap arrives as a mask. A register FIS that shows up when no transmit is outstanding sets a sticky protocol error.

Top module: `ncq_issue_sched`

## Requirements
- R1: A posting (`post_valid_i`) to slot s sets bit s of both `issue_map_o` and `active_map_o` on the next clock edge. Posting slots 0, 2, 5 and 8 makes both maps read 0x00000125.
- R2: The effective depth is min(NUM_SLOTS, `dev_depth_i`). A posting to a slot at or above it leaves both maps unchanged and sets `range_err_o`, which stays set until reset.
- R3: While `tx_req_o` is high, `tx_tag_o` equals the slot index of the command being sent, and that slot's issue bit is set.
- R4: Among the issue bits below the effective depth, the lowest-numbered one is sent first.
- R5: While `rx_pending_i` is high and no transmit is requested, `tx_req_o` stays low in the following cycle.
- R6: `tx_req_o` and `tx_tag_o` hold until `tx_ack_i`. After the acknowledge, no new request is raised until a register FIS (`rx_type_i` = 0x34) has been accepted.
- R7: A register FIS accepted while a transmit is outstanding clears that tag's issue bit on the next edge and leaves the active bit alone. `irq_o` pulses for one cycle only if `rx_ibit_i` is 1.
- R8: A register FIS while no transmit is outstanding leaves the maps unchanged, sets no interrupt, and sets `proto_err_o` until reset.
- R9: `done_valid_i` clears every active bit set in `done_mask_i` and leaves the issue bitmap unchanged.
- R10: After reset both maps are zero and `tx_req_o`, `irq_o`, `range_err_o` and `proto_err_o` are low.
- R11: A FIS of any other type received while waiting for the register FIS is ignored. The issue bitmap is unchanged and no new request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_depth_i | input | 6 | Queue depth reported by the device |
| post_valid_i | input | 1 | Host posts a command slot |
| post_slot_i | input | 5 | Slot being posted |
| done_valid_i | input | 1 | Completion mask valid |
| done_mask_i | input | 32 | Slots whose active bit is cleared |
| rx_pending_i | input | 1 | Inbound FIS waiting to be serviced |
| rx_valid_i | input | 1 | Inbound FIS header valid |
| rx_type_i | input | 8 | Inbound FIS type code |
| rx_ibit_i | input | 1 | Interrupt bit of the inbound FIS |
| tx_ack_i | input | 1 | Link has taken the command |
| tx_req_o | output | 1 | Command transmit request |
| tx_tag_o | output | 5 | Tag (slot index) of the command |
| issue_map_o | output | 32 | Issue bitmap |
| active_map_o | output | 32 | Active bitmap |
| irq_o | output | 1 | Interrupt pulse |
| range_err_o | output | 1 | Sticky out-of-depth posting error |
| proto_err_o | output | 1 | Sticky unexpected register FIS error |

## Verification
Several properties are checked on every cycle:
- Requests hold until acknowledged, and the interlock after an acknowledge drops the request.
- The idle scheduler yields to inbound traffic.
- The tag being sent names a set issue bit, and no lower eligible slot was waiting when the request rose.
- Accepted register FISes clear their bit, and a FIS with a clear interrupt bit raises no pulse.
- Rejected postings raise the range flag.

Only the bench scenarios can show the following:
- The exact bitmap values after mixed postings and completions.
- The full issue order across many rounds with random depths.
- That foreign FIS types and stray register FISes leave the maps untouched.

// File: rtl/ncq_pkg.sv
package ncq_pkg;
  localparam logic [7:0] FIS_REG_D2H = 8'h34;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } sched_state_e;
endpackage

// File: rtl/ncq_slot_maps.sv
module ncq_slot_maps #(
  parameter int NUM_SLOTS = 32,
  parameter int TAG_W     = $clog2(NUM_SLOTS),
  parameter int DEPTH_W   = TAG_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DEPTH_W-1:0]   eff_depth_i,
  input  logic                 post_valid_i,
  input  logic [TAG_W-1:0]     post_slot_i,
  input  logic                 done_valid_i,
  input  logic [NUM_SLOTS-1:0] done_mask_i,
  input  logic                 clr_en_i,
  input  logic [TAG_W-1:0]     clr_tag_i,
  output logic [NUM_SLOTS-1:0] issue_q_o,
  output logic [NUM_SLOTS-1:0] active_q_o,
  output logic [NUM_SLOTS-1:0] depth_mask_o,
  output logic                 range_err_o
);
  logic [NUM_SLOTS-1:0] issue_d, active_d;
  logic                 post_ok;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mask
    assign depth_mask_o[g] = (DEPTH_W'(g) < eff_depth_i);
  end

  assign post_ok = post_valid_i && ({1'b0, post_slot_i} < eff_depth_i);

  always_comb begin
    issue_d  = issue_q_o;
    active_d = active_q_o;
    if (clr_en_i)     issue_d[clr_tag_i] = 1'b0;
    if (done_valid_i) active_d = active_d & ~done_mask_i;
    // a fresh posting wins over a same-cycle clear
    if (post_ok) begin
      issue_d[post_slot_i]  = 1'b1;
      active_d[post_slot_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_q_o   <= '0;
      active_q_o  <= '0;
      range_err_o <= 1'b0;
    end else begin
      issue_q_o  <= issue_d;
      active_q_o <= active_d;
      if (post_valid_i && !post_ok) range_err_o <= 1'b1;
    end
  end

  assert_range_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_valid_i && !post_ok |=> range_err_o);

  assert_clear_on_d2h_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i && !(post_ok && post_slot_i == clr_tag_i) |=> !issue_q_o[$past(clr_tag_i)]);
endmodule

// File: rtl/ncq_slot_pick.sv
module ncq_slot_pick #(
  parameter int NUM_SLOTS = 32,
  parameter int TAG_W     = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] elig_i,
  output logic                 found_o,
  output logic [TAG_W-1:0]     slot_o
);
  always_comb begin
    found_o = 1'b0;
    slot_o  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        found_o = 1'b1;
        slot_o  = TAG_W'(i);
      end
    end
  end
endmodule

// File: rtl/ncq_issue_fsm.sv
module ncq_issue_fsm
  import ncq_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int TAG_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pick_found_i,
  input  logic [TAG_W-1:0] pick_slot_i,
  input  logic             rx_pending_i,
  input  logic             tx_ack_i,
  input  logic             reg_fis_i,
  input  logic             reg_ibit_i,
  output logic             tx_req_o,
  output logic [TAG_W-1:0] tx_tag_o,
  output logic             clr_en_o,
  output logic [TAG_W-1:0] clr_tag_o,
  output logic             irq_o,
  output logic             proto_err_o
);
  sched_state_e     state_q, state_d;
  logic [TAG_W-1:0] tag_q;
  logic             accept;

  assign accept    = reg_fis_i && (state_q == ST_WAIT);
  assign tx_req_o  = (state_q == ST_SEND);
  assign tx_tag_o  = tag_q;
  assign clr_en_o  = accept;
  assign clr_tag_o = tag_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (!rx_pending_i && pick_found_i) state_d = ST_SEND;
      ST_SEND: if (tx_ack_i) state_d = ST_WAIT;
      ST_WAIT: if (accept) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      tag_q       <= '0;
      irq_o       <= 1'b0;
      proto_err_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && state_d == ST_SEND) tag_q <= pick_slot_i;
      irq_o <= accept && reg_ibit_i;
      if (reg_fis_i && !accept) proto_err_o <= 1'b1;
    end
  end

  assert_hold_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o && !tx_ack_i |=> tx_req_o && $stable(tx_tag_o));

  assert_interlock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o && tx_ack_i |=> !tx_req_o);

  assert_yield_rx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_req_o && rx_pending_i |=> !tx_req_o);

  assert_quiet_d2h_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_fis_i && !reg_ibit_i |=> !irq_o);

  assert_stray_d2h_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_fis_i && !tx_req_o && !clr_en_o |=> proto_err_o && !irq_o);
endmodule

// File: rtl/ncq_issue_sched.sv
module ncq_issue_sched
  import ncq_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int TAG_W    = $clog2(NUM_SLOTS),
  localparam int DEPTH_W  = TAG_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DEPTH_W-1:0]   dev_depth_i,
  input  logic                 post_valid_i,
  input  logic [TAG_W-1:0]     post_slot_i,
  input  logic                 done_valid_i,
  input  logic [NUM_SLOTS-1:0] done_mask_i,
  input  logic                 rx_pending_i,
  input  logic                 rx_valid_i,
  input  logic [7:0]           rx_type_i,
  input  logic                 rx_ibit_i,
  input  logic                 tx_ack_i,
  output logic                 tx_req_o,
  output logic [TAG_W-1:0]     tx_tag_o,
  output logic [NUM_SLOTS-1:0] issue_map_o,
  output logic [NUM_SLOTS-1:0] active_map_o,
  output logic                 irq_o,
  output logic                 range_err_o,
  output logic                 proto_err_o
);
  logic [DEPTH_W-1:0]   eff_depth;
  logic [NUM_SLOTS-1:0] depth_mask, elig;
  logic                 pick_found, clr_en, reg_fis;
  logic [TAG_W-1:0]     pick_slot, clr_tag;

  assign eff_depth = (dev_depth_i < DEPTH_W'(NUM_SLOTS)) ? dev_depth_i : DEPTH_W'(NUM_SLOTS);
  assign elig      = issue_map_o & depth_mask;
  assign reg_fis   = rx_valid_i && (rx_type_i == FIS_REG_D2H);

  ncq_slot_maps #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W), .DEPTH_W(DEPTH_W)) u_maps (
    .clk_i, .rst_ni,
    .eff_depth_i (eff_depth),
    .post_valid_i, .post_slot_i, .done_valid_i, .done_mask_i,
    .clr_en_i    (clr_en),
    .clr_tag_i   (clr_tag),
    .issue_q_o   (issue_map_o),
    .active_q_o  (active_map_o),
    .depth_mask_o(depth_mask),
    .range_err_o
  );

  ncq_slot_pick #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W)) u_pick (
    .elig_i (elig),
    .found_o(pick_found),
    .slot_o (pick_slot)
  );

  ncq_issue_fsm #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W)) u_fsm (
    .clk_i, .rst_ni,
    .pick_found_i(pick_found),
    .pick_slot_i (pick_slot),
    .rx_pending_i, .tx_ack_i,
    .reg_fis_i   (reg_fis),
    .reg_ibit_i  (rx_ibit_i),
    .tx_req_o, .tx_tag_o,
    .clr_en_o    (clr_en),
    .clr_tag_o   (clr_tag),
    .irq_o, .proto_err_o
  );

  assert_tag_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> issue_map_o[tx_tag_o]);

  assert_lowest_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_req_o) |-> ($past(elig) & ((NUM_SLOTS'(1) << tx_tag_o) - NUM_SLOTS'(1))) == '0);
endmodule

// File: tb/ncq_issue_sched_bench.sv
`timescale 1ns/1ps
module ncq_issue_sched_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  dev_depth = 6'd32;
  logic        post_valid = 0, done_valid = 0, rx_pending = 0, rx_valid = 0, rx_ibit = 0, tx_ack = 0;
  logic [4:0]  post_slot = '0;
  logic [31:0] done_mask = '0;
  logic [7:0]  rx_type = '0;
  logic        tx_req, irq, range_err, proto_err;
  logic [4:0]  tx_tag;
  logic [31:0] issue_map, active_map;

  logic [31:0] m_issue = '0, m_active = '0;
  logic        m_range = 0;
  int          checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  ncq_issue_sched u_ncq_issue_sched (
    .clk_i(clk), .rst_ni(rst_n), .dev_depth_i(dev_depth),
    .post_valid_i(post_valid), .post_slot_i(post_slot),
    .done_valid_i(done_valid), .done_mask_i(done_mask),
    .rx_pending_i(rx_pending), .rx_valid_i(rx_valid), .rx_type_i(rx_type), .rx_ibit_i(rx_ibit),
    .tx_ack_i(tx_ack), .tx_req_o(tx_req), .tx_tag_o(tx_tag),
    .issue_map_o(issue_map), .active_map_o(active_map),
    .irq_o(irq), .range_err_o(range_err), .proto_err_o(proto_err)
  );

  function automatic int eff_of(logic [5:0] d);
    return (d < 6'd32) ? int'(d) : 32;
  endfunction

  function automatic int lowest(logic [31:0] m, int eff);
    for (int i = 0; i < eff; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic check_maps(string req);
    check(issue_map == m_issue, req, issue_map, m_issue);
    check(active_map == m_active, req, active_map, m_active);
  endtask

  task automatic post(int s);
    post_valid = 1; post_slot = 5'(s);
    @(negedge clk);
    post_valid = 0;
    if (s < eff_of(dev_depth)) begin
      m_issue[s] = 1'b1; m_active[s] = 1'b1;
    end else m_range = 1'b1;
  endtask

  task automatic send_fis(logic [7:0] t, logic ib);
    rx_valid = 1; rx_type = t; rx_ibit = ib;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic serve(logic ib);
    int exp_tag, n;
    n = 0;
    while (!tx_req && n < 50) begin @(negedge clk); n++; end
    exp_tag = lowest(m_issue, eff_of(dev_depth));
    check(tx_req == 1'b1, "R6 request raised", 32'(tx_req), 1);
    check(int'(tx_tag) == exp_tag, "R3/R4 tag order", 32'(tx_tag), 32'(exp_tag));
    @(negedge clk);
    check(tx_req && int'(tx_tag) == exp_tag, "R6 hold until ack", 32'(tx_req), 1);
    tx_ack = 1;
    @(negedge clk);
    tx_ack = 0;
    check(tx_req == 1'b0, "R6 interlock", 32'(tx_req), 0);
    @(negedge clk);
    check(tx_req == 1'b0, "R6 interlock", 32'(tx_req), 0);
    send_fis(8'h34, ib);
    if (exp_tag >= 0) m_issue[exp_tag] = 1'b0;
    check(irq == ib, "R7 irq follows I bit", 32'(irq), 32'(ib));
    check_maps("R7 issue bit cleared");
    @(negedge clk);
    check(irq == 1'b0, "R7 irq one cycle", 32'(irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", checks, 0);
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check(issue_map == 0 && active_map == 0, "R10 maps", issue_map | active_map, 0);
    check(!tx_req && !irq && !range_err && !proto_err, "R10 flags",
          {tx_req, irq, range_err, proto_err}, 0);

    // R8 stray register FIS while idle
    rx_pending = 1;
    send_fis(8'h34, 1'b1);
    check(proto_err == 1'b1, "R8 proto err", 32'(proto_err), 1);
    check(irq == 1'b0, "R8 no irq", 32'(irq), 0);
    check_maps("R8 maps unchanged");

    // R1 posting with inbound pending; R5 yield
    post(0); post(2); post(5); post(8);
    check(issue_map == 32'h125, "R1 issue map", issue_map, 32'h125);
    check(active_map == 32'h125, "R1 active map", active_map, 32'h125);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(tx_req == 1'b0, "R5 yield to inbound", 32'(tx_req), 0);
    end
    rx_pending = 0;
    serve(1'b0);
    // R11 foreign FIS while waiting
    begin
      int n = 0;
      while (!tx_req && n < 20) begin @(negedge clk); n++; end
    end
    check(int'(tx_tag) == 2, "R4 second slot", 32'(tx_tag), 2);
    tx_ack = 1; @(negedge clk); tx_ack = 0;
    send_fis(8'h41, 1'b1);
    send_fis(8'hA1, 1'b0);
    check_maps("R11 foreign FIS ignored");
    check(tx_req == 1'b0 && irq == 1'b0, "R11 no request", {tx_req, irq}, 0);
    send_fis(8'h34, 1'b0);
    m_issue[2] = 1'b0;
    check_maps("R7 slot 2 cleared");
    serve(1'b0); serve(1'b1);
    check(issue_map == 0, "R7 all issued", issue_map, 0);
    check(active_map == 32'h125, "R7 active kept", active_map, 32'h125);

    // R9 completion mask
    done_valid = 1; done_mask = 32'h24;
    @(negedge clk);
    done_valid = 0; m_active &= ~32'h24;
    check(active_map == 32'h101, "R9 completion", active_map, 32'h101);
    done_valid = 1; done_mask = 32'h101;
    @(negedge clk);
    done_valid = 0; m_active = '0;
    check_maps("R9 all complete");

    // R2 depth window
    dev_depth = 6'd4;
    check(range_err == 1'b0, "R2 no error yet", 32'(range_err), 0);
    rx_pending = 1;
    post(6);
    check(range_err == 1'b1, "R2 range err", 32'(range_err), 1);
    check_maps("R2 post ignored");
    post(3); post(4);
    check_maps("R2 boundary slot");
    rx_pending = 0;
    serve(1'b0);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      int np;
      dev_depth = 6'($urandom_range(1, 32));
      rx_pending = 1;
      np = $urandom_range(1, 8);
      for (int k = 0; k < np; k++) post($urandom_range(0, 31));
      check_maps("R1 random post");
      check(range_err == m_range, "R2 sticky", 32'(range_err), 32'(m_range));
      rx_pending = 0;
      while (m_issue != 0) serve(1'(($urandom() >> 3) & 1));
      done_valid = 1; done_mask = m_active;
      @(negedge clk);
      done_valid = 0; m_active = '0;
      check_maps("R9 random done");
    end
    check(proto_err == 1'b1, "R8 sticky", 32'(proto_err), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule